// File: doc/BRIEF.md
# Register Readiness Scoreboard with Operand Wakeup

This block sits beside an issue queue and tracks which physical registers hold valid results. A ready bit is kept for every tracked register, covering the integer and floating-point physical registers together. When an instruction is written into an issue slot, each of its source operands is resolved against that bit vector. An operand that is not yet ready is remembered as a waiting operand of that slot, along with its register tag. The instruction's destination register, if tracked, has its bit cleared.

A completion broadcast carries the tag of a register whose producer has finished. In one cycle every waiting operand that matches the tag becomes ready, and the register's bit is set. A slot whose operands are all ready raises its bit in `slot_ready`, which feeds the select logic. Slots that issue or are squashed are released through `drop_mask`. Releasing a slot also discards its waiting operands, and only operands that were still waiting have anything to discard.

The scoreboard is also consulted at insert time, with the same-cycle broadcast forwarded. This covers a producer that finished while the consumer was still travelling between pipeline stages. Tags at or above the tracked register count are treated as always ready and are never stored or updated.

Top module: `sbw_wakeup`

## Requirements
- R1: While reset is high and in the cycle after it, `reg_ready`, `slot_ready` and `dup_producer_err` are all zero.
- R2: An insert with a valid tracked destination clears that register's ready bit in the next cycle. It wins over a completion of the same register in the same cycle.
- R3: A completion with a tracked tag sets that register's ready bit in the next cycle.
- R4: At insert, a source operand is ready if its rename flag is set, if its register bit is set, or if the same cycle carries a completion of that tag. Only the other operands are stored as waiting.
- R5: A tag at or above INT_REGS+FP_REGS is untracked. As a source it is ready. As a destination or completion tag it changes no ready bit.
- R6: A completion clears every waiting operand with a matching tag, in all slots, at once. Each such slot shows the effect in `slot_ready` one cycle later.
- R7: A set bit in `drop_mask` empties that slot: its `slot_ready` is low in the next cycle and later completions have no effect on it. An insert to the same slot in the same cycle takes precedence over the drop.
- R8: `dup_producer_err` pulses high in the cycle after an insert whose tracked destination still has waiting operands in some slot. No pulse occurs when a completion of that same tag arrives in the insert cycle.
- R9: `slot_ready[i]` is high exactly when slot i holds an instruction with no waiting operand. A slot inserted with all operands ready is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Write one instruction into a slot this cycle |
| ins_slot | input | SLOT_W | Target slot of the insert |
| ins_src_tag | input | SRCS*TAG_W | Source register tags, operand s in bits [s*TAG_W +: TAG_W] |
| ins_src_rdy | input | SRCS | Per-operand ready flag supplied by rename |
| ins_dst_valid | input | 1 | The inserted instruction writes a register |
| ins_dst_tag | input | TAG_W | Destination register tag |
| cmp_valid | input | 1 | Completion broadcast present |
| cmp_tag | input | TAG_W | Register written by the completing producer |
| drop_mask | input | SLOTS | Slots released this cycle |
| reg_ready | output | NUM_REGS | Ready bit per tracked register |
| slot_ready | output | SLOTS | Slot holds an instruction with all operands ready |
| dup_producer_err | output | 1 | Producer allocated for a register that still had waiters |

## Verification
The assertions assume a well-formed stream from the neighbouring stages. At most one insert and one completion arrive per cycle, and an insert is aimed at a slot the surrounding logic considers free or being released. They also assume a completion broadcast refers to a register that was previously allocated. The stimulus honours one-insert-per-cycle by construction. It draws tags from a narrow set, with both tracked and untracked values, so collisions between inserts, completions and waiting operands happen often. Overwriting an occupied slot is allowed in the random phase, because the requirements define it as a plain rewrite.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int DEF_INT_REGS = 24;
  localparam int DEF_FP_REGS  = 16;
  localparam int DEF_SLOTS    = 8;
  localparam int DEF_SRCS     = 2;

  // One spare bit so every tag width has an untracked range above the register file.
  function automatic int tag_bits(input int nregs);
    return $clog2(nregs) + 1;
  endfunction
endpackage

// File: rtl/sbw_regbits.sv
module sbw_regbits #(
  parameter int NUM_REGS = 40,
  parameter int TAG_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_vld,
  input  logic [TAG_W-1:0]    set_tag,
  input  logic                clr_vld,
  input  logic [TAG_W-1:0]    clr_tag,
  output logic [NUM_REGS-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (clr_vld && clr_tag == TAG_W'(r))
          bits[r] <= 1'b0;
        else if (set_vld && set_tag == TAG_W'(r))
          bits[r] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbw_slot.sv
module sbw_slot #(
  parameter int SRCS  = 2,
  parameter int TAG_W = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [SRCS*TAG_W-1:0] wr_tags,
  input  logic [SRCS-1:0]       wr_wait,
  input  logic                  drop,
  input  logic                  wake_vld,
  input  logic [TAG_W-1:0]      wake_tag,
  input  logic [TAG_W-1:0]      query_tag,
  output logic                  ready,
  output logic                  has_waiter,
  output logic [SRCS-1:0]       waits,
  output logic [SRCS*TAG_W-1:0] tags
);
  logic vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= 1'b0;
      waits <= '0;
      tags  <= '0;
    end else if (wr) begin
      vld   <= 1'b1;
      waits <= wr_wait;
      tags  <= wr_tags;
    end else if (drop) begin
      vld   <= 1'b0;
      waits <= '0;
    end else begin
      for (int s = 0; s < SRCS; s++)
        if (wake_vld && tags[s*TAG_W +: TAG_W] == wake_tag)
          waits[s] <= 1'b0;
    end
  end

  always_comb begin
    has_waiter = 1'b0;
    for (int s = 0; s < SRCS; s++)
      if (waits[s] && tags[s*TAG_W +: TAG_W] == query_tag)
        has_waiter = 1'b1;
  end

  assign ready = vld & ~|waits;
endmodule

// File: rtl/sbw_wakeup.sv
module sbw_wakeup
  import sbw_pkg::*;
#(
  parameter int INT_REGS = DEF_INT_REGS,
  parameter int FP_REGS  = DEF_FP_REGS,
  parameter int SLOTS    = DEF_SLOTS,
  parameter int SRCS     = DEF_SRCS,
  localparam int NUM_REGS = INT_REGS + FP_REGS,
  localparam int TAG_W    = tag_bits(NUM_REGS),
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ins_valid,
  input  logic [SLOT_W-1:0]     ins_slot,
  input  logic [SRCS*TAG_W-1:0] ins_src_tag,
  input  logic [SRCS-1:0]       ins_src_rdy,
  input  logic                  ins_dst_valid,
  input  logic [TAG_W-1:0]      ins_dst_tag,
  input  logic                  cmp_valid,
  input  logic [TAG_W-1:0]      cmp_tag,
  input  logic [SLOTS-1:0]      drop_mask,
  output logic [NUM_REGS-1:0]   reg_ready,
  output logic [SLOTS-1:0]      slot_ready,
  output logic                  dup_producer_err
);
  localparam logic [TAG_W-1:0] LIMIT = TAG_W'(NUM_REGS);

  logic                  cmp_hit, alloc_hit;
  logic [SRCS-1:0]       src_wait;
  logic [SLOTS-1:0]      slot_waiter;
  logic [SRCS-1:0]       slot_waits [SLOTS];
  logic [SRCS*TAG_W-1:0] slot_tags  [SLOTS];
  logic                  err_d;

  assign cmp_hit   = cmp_valid && (cmp_tag < LIMIT);
  assign alloc_hit = ins_valid && ins_dst_valid && (ins_dst_tag < LIMIT);

  sbw_regbits #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_bits (
    .clk     (clk),
    .rst     (rst),
    .set_vld (cmp_hit),
    .set_tag (cmp_tag),
    .clr_vld (alloc_hit),
    .clr_tag (ins_dst_tag),
    .bits    (reg_ready)
  );

  // Insert-time resolution: rename flag, scoreboard bit, or same-cycle broadcast.
  always_comb begin
    for (int s = 0; s < SRCS; s++) begin
      logic [TAG_W-1:0] t;
      logic             hit;
      t   = ins_src_tag[s*TAG_W +: TAG_W];
      hit = 1'b0;
      for (int r = 0; r < NUM_REGS; r++)
        if (t == TAG_W'(r)) hit = reg_ready[r];
      src_wait[s] = !(ins_src_rdy[s] || (t >= LIMIT) || hit || (cmp_hit && cmp_tag == t));
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    sbw_slot #(.SRCS(SRCS), .TAG_W(TAG_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .wr         (ins_valid && ins_slot == SLOT_W'(i)),
      .wr_tags    (ins_src_tag),
      .wr_wait    (src_wait),
      .drop       (drop_mask[i]),
      .wake_vld   (cmp_hit),
      .wake_tag   (cmp_tag),
      .query_tag  (ins_dst_tag),
      .ready      (slot_ready[i]),
      .has_waiter (slot_waiter[i]),
      .waits      (slot_waits[i]),
      .tags       (slot_tags[i])
    );
  end

  assign err_d = alloc_hit && (|slot_waiter) && !(cmp_hit && cmp_tag == ins_dst_tag);

  always_ff @(posedge clk) begin
    if (rst) dup_producer_err <= 1'b0;
    else     dup_producer_err <= err_d;
  end
endmodule

// File: rtl/sbw_wakeup_chk.sv
module sbw_wakeup_chk #(
  parameter int NUM_REGS = 40,
  parameter int TAG_W    = 7,
  parameter int SLOTS    = 8,
  parameter int SRCS     = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ins_valid,
  input logic                  ins_dst_valid,
  input logic [TAG_W-1:0]      ins_dst_tag,
  input logic                  cmp_valid,
  input logic [TAG_W-1:0]      cmp_tag,
  input logic [NUM_REGS-1:0]   reg_ready,
  input logic [SLOTS-1:0]      slot_ready,
  input logic                  dup_producer_err,
  input logic [SRCS-1:0]       slot_waits [SLOTS],
  input logic [SRCS*TAG_W-1:0] slot_tags  [SLOTS]
);
  localparam logic [TAG_W-1:0] LIMIT = TAG_W'(NUM_REGS);

  function automatic logic stale_on(input logic [TAG_W-1:0] t);
    logic f;
    f = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      for (int s = 0; s < SRCS; s++)
        if (slot_waits[i][s] && slot_tags[i][s*TAG_W +: TAG_W] == t) f = 1'b1;
    return f;
  endfunction

  function automatic logic bit_at(input logic [TAG_W-1:0] t);
    logic b;
    b = 1'b0;
    for (int r = 0; r < NUM_REGS; r++)
      if (t == TAG_W'(r)) b = reg_ready[r];
    return b;
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (reg_ready == '0 && slot_ready == '0 && !dup_producer_err)); // R1

  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_dst_valid && ins_dst_tag < LIMIT) |=> !bit_at($past(ins_dst_tag))); // R2

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_tag < LIMIT && !(ins_valid && ins_dst_valid && ins_dst_tag == cmp_tag))
      |=> bit_at($past(cmp_tag))); // R3

  AST_UNTRACKED_STABLE: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_tag >= LIMIT && !(ins_valid && ins_dst_valid)) |=> $stable(reg_ready)); // R5

  AST_NO_STALE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_tag < LIMIT) |=> !stale_on($past(cmp_tag))); // R6

  AST_ERR_NEEDS_INSERT: assert property (@(posedge clk) disable iff (rst)
    dup_producer_err |-> $past(ins_valid && ins_dst_valid)); // R8
endmodule

bind sbw_wakeup sbw_wakeup_chk #(
  .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .SLOTS(SLOTS), .SRCS(SRCS)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .ins_valid        (ins_valid),
  .ins_dst_valid    (ins_dst_valid),
  .ins_dst_tag      (ins_dst_tag),
  .cmp_valid        (cmp_valid),
  .cmp_tag          (cmp_tag),
  .reg_ready        (reg_ready),
  .slot_ready       (slot_ready),
  .dup_producer_err (dup_producer_err),
  .slot_waits       (slot_waits),
  .slot_tags        (slot_tags)
);

// File: tb/test_sbw_wakeup.sv
`timescale 1ns/1ps
module test_sbw_wakeup;
  import sbw_pkg::*;
  localparam int NUM_REGS = DEF_INT_REGS + DEF_FP_REGS;
  localparam int TAG_W    = tag_bits(NUM_REGS);
  localparam int SLOTS    = DEF_SLOTS;
  localparam int SRCS     = DEF_SRCS;
  localparam int SLOT_W   = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst;
  logic ins_valid, ins_dst_valid, cmp_valid;
  logic [SLOT_W-1:0] ins_slot;
  logic [SRCS*TAG_W-1:0] ins_src_tag;
  logic [SRCS-1:0] ins_src_rdy;
  logic [TAG_W-1:0] ins_dst_tag, cmp_tag;
  logic [SLOTS-1:0] drop_mask;
  logic [NUM_REGS-1:0] reg_ready;
  logic [SLOTS-1:0] slot_ready;
  logic dup_producer_err;

  always #2 clk = ~clk;

  sbw_wakeup i_sbw_wakeup (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_slot(ins_slot),
    .ins_src_tag(ins_src_tag), .ins_src_rdy(ins_src_rdy),
    .ins_dst_valid(ins_dst_valid), .ins_dst_tag(ins_dst_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .drop_mask(drop_mask),
    .reg_ready(reg_ready), .slot_ready(slot_ready), .dup_producer_err(dup_producer_err)
  );

  // Reference state built from the requirements.
  logic [NUM_REGS-1:0] m_bits;
  logic [SLOTS-1:0]    m_vld;
  logic [SRCS-1:0]     m_wt [SLOTS];
  logic [TAG_W-1:0]    m_tg [SLOTS][SRCS];
  logic                m_err;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic trk(input logic [TAG_W-1:0] t);
    return int'(t) < NUM_REGS;
  endfunction

  function automatic logic [SLOTS-1:0] exp_ready();
    logic [SLOTS-1:0] v;
    for (int i = 0; i < SLOTS; i++) v[i] = m_vld[i] && (m_wt[i] == '0);
    return v;
  endfunction

  task automatic model_reset();
    m_bits = '0; m_vld = '0; m_err = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      m_wt[i] = '0;
      for (int s = 0; s < SRCS; s++) m_tg[i][s] = '0;
    end
  endtask

  task automatic model_step();
    logic cmp_hit, alloc, waiter;
    logic [SRCS-1:0] w;
    cmp_hit = cmp_valid && trk(cmp_tag);
    alloc   = ins_valid && ins_dst_valid && trk(ins_dst_tag);
    waiter  = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      for (int s = 0; s < SRCS; s++)
        if (m_wt[i][s] && m_tg[i][s] == ins_dst_tag) waiter = 1'b1;
    for (int s = 0; s < SRCS; s++) begin
      logic [TAG_W-1:0] t;
      t = ins_src_tag[s*TAG_W +: TAG_W];
      w[s] = !(ins_src_rdy[s] || !trk(t) || m_bits[t] || (cmp_hit && cmp_tag == t));
    end
    for (int i = 0; i < SLOTS; i++) begin
      if (ins_valid && int'(ins_slot) == i) begin
        m_vld[i] = 1'b1; m_wt[i] = w;
        for (int s = 0; s < SRCS; s++) m_tg[i][s] = ins_src_tag[s*TAG_W +: TAG_W];
      end else if (drop_mask[i]) begin
        m_vld[i] = 1'b0; m_wt[i] = '0;
      end else begin
        for (int s = 0; s < SRCS; s++)
          if (cmp_hit && m_tg[i][s] == cmp_tag) m_wt[i][s] = 1'b0;
      end
    end
    if (cmp_hit) m_bits[cmp_tag] = 1'b1;
    if (alloc)   m_bits[ins_dst_tag] = 1'b0;
    m_err = alloc && waiter && !(cmp_hit && cmp_tag == ins_dst_tag);
  endtask

  task automatic compare(input string req);
    checks++;
    if (slot_ready !== exp_ready()) begin
      fails++; $display("FAIL %s slot_ready actual=%b expected=%b", req, slot_ready, exp_ready());
    end
    checks++;
    if (reg_ready !== m_bits) begin
      fails++; $display("FAIL %s reg_ready actual=%h expected=%h", req, reg_ready, m_bits);
    end
    checks++;
    if (dup_producer_err !== m_err) begin
      fails++; $display("FAIL %s dup_producer_err actual=%b expected=%b", req, dup_producer_err, m_err);
    end
  endtask

  task automatic idle_in();
    ins_valid = 0; ins_slot = '0; ins_src_tag = '0; ins_src_rdy = '0;
    ins_dst_valid = 0; ins_dst_tag = '0; cmp_valid = 0; cmp_tag = '0; drop_mask = '0;
  endtask

  task automatic put(input int slot, input int t0, input int t1, input logic [1:0] rdy,
                     input logic dv, input int dt);
    ins_valid = 1; ins_slot = SLOT_W'(slot);
    ins_src_tag = {TAG_W'(t1), TAG_W'(t0)}; ins_src_rdy = rdy;
    ins_dst_valid = dv; ins_dst_tag = TAG_W'(dt);
  endtask

  task automatic done_tag(input int t);
    cmp_valid = 1; cmp_tag = TAG_W'(t);
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    #0.5 model_step();
    @(negedge clk);
    compare(req);
    idle_in();
  endtask

  function automatic int pick_tag();
    int r;
    r = $urandom_range(0, 9);
    if (r < 7) return $urandom_range(0, 5);
    if (r < 9) return $urandom_range(NUM_REGS, NUM_REGS + 2);
    return (1 << TAG_W) - 1;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_in();
    rst = 1;
    model_reset();
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst = 0;
    @(negedge clk);
    compare("R1");

    done_tag(3);                        cyc("R3");
    put(0, 3, 5, 2'b00, 1, 7);          cyc("R4");
    put(1, 5, NUM_REGS, 2'b00, 1, 9); done_tag(5); cyc("R6");
    cyc("R5");
    put(2, 7, 7, 2'b00, 1, 10);         cyc("R4");
    put(3, 7, 11, 2'b10, 1, 12);        cyc("R4");
    put(4, 0, 0, 2'b11, 1, 7);          cyc("R8");
    cyc("R8");
    done_tag(7);                        cyc("R6");
    put(5, 1, 1, 2'b11, 1, 3); done_tag(3); cyc("R2");
    done_tag(NUM_REGS + 9);             cyc("R5");
    put(6, 0, 1, 2'b11, 1, NUM_REGS + 4); cyc("R5");
    put(2, 20, 1, 2'b10, 0, 0); drop_mask = 8'b0000_0100; cyc("R7");
    drop_mask = 8'b0000_1000;           cyc("R7");
    drop_mask = 8'b0000_0100;           cyc("R7");
    done_tag(20);                       cyc("R7");
    put(7, 30, 31, 2'b11, 0, 0);        cyc("R9");
    put(0, 6, 6, 2'b00, 1, 6);          cyc("R8");
    put(1, 2, 2, 2'b00, 1, 6); done_tag(6); cyc("R4");

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) != 0)
        put($urandom_range(0, SLOTS - 1), pick_tag(), pick_tag(),
            2'($urandom_range(0, 3) & $urandom_range(0, 3)),
            1'($urandom_range(0, 1)), pick_tag());
      if ($urandom_range(0, 2) == 0) done_tag(pick_tag());
      if ($urandom_range(0, 4) == 0) drop_mask = SLOTS'(1 << $urandom_range(0, SLOTS - 1));
      cyc("R6");
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule